// File: doc/BRIEF.md
# Software-Loaded Translation Buffer with Zone Protection

This block translates effective addresses to physical addresses through a fully associative table that software fills one entry at a time. Each entry is loaded through two write strobes that share an index operand and a 32-bit data word. The tag-side write sets the virtual page, the page size, the valid flag and eight attribute bits, and it captures the current process ID. The permission-side write sets the physical page, the write and execute grants and the zone index of the entry.

A lookup presents an effective address, an access kind (fetch, load or store), a user/supervisor flag and a 32-bit zone protection word. One cycle later the block returns a status (hit, instruction miss, data miss or protection fault), the physical address, the granted read and write rights and the attributes of the matching entry. On a miss it also updates a fault address register and a syndrome register that a trap handler can read. Page table walking and exception dispatch belong to the surrounding core.

Top module: `swtlb_zone`

## Requirements
- R1: Both write strobes pick the target entry from the low 6 bits of `wr_index`, so index 64+k writes entry k. Upper index bits are ignored.
- R2: A tag write takes the size code n from data bits 9:7 (page size 1 KB × 4^n, n = 0..7), the virtual page from bits 31:10 with its low 2n bits cleared, and the valid flag from bit 6. It also stores `cur_pid` as the entry's process tag.
- R3: A tag write stores data bits 7:0 as attributes, and a hit returns them on `rsp_attr`.
- R4: A permission write stores the physical page from bits 31:10, the write grant from bit 8, the execute grant from bit 9 and the zone index from bits 7:4.
- R5: An entry matches when it is valid, when its process tag equals `cur_pid` or is zero, and when the address equals its virtual page above the page-size boundary. When several entries match, the lowest index wins.
- R6: On a hit, the physical address takes the entry's physical page above the page boundary and the effective address bits below it.
- R7: `rsp_status` encodes 0 for a granted access, 1 for an instruction miss (fetch, no match), 2 for a data miss (load or store, no match) and 3 for a protection fault. Access kind encodes 0 for fetch, 1 for load and 2 for store. On any status other than 0, `rsp_pa`, `rsp_rd`, `rsp_wr` and `rsp_attr` are zero.
- R8: A miss loads `fault_addr` with the effective address. It loads `syndrome` with 0x00800000 for a store and 0 for a load or a fetch. Neither register changes on a hit, on a protection fault or while no lookup is made.
- R9: For a fetch, zone code 0 with the user flag set faults. Zone code 3 grants read and write. Any other code faults if the entry's execute grant is clear; otherwise it grants read, plus write if the entry's write grant is set.
- R10: For a load or a store, zone code 0 with the user flag set faults, and zone code 3 grants read and write. For any other code, an entry with the write grant gets read and write. Without it, a load gets read only and a store faults.
- R11: The zone code is the 2-bit field of `zpr` at bits (31-2z):(30-2z), where z is the entry's zone index.
- R12: A lookup requested in one cycle is answered in the next with `rsp_valid` high. A write lands at the clock edge, so a lookup made in the same cycle as a write still sees the old entry, and a lookup made in the next cycle sees the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_tag | input | 1 | Tag-side write strobe |
| wr_perm | input | 1 | Permission-side write strobe |
| wr_index | input | 32 | Entry index operand (low 6 bits used) |
| wr_data | input | 32 | Write data word |
| cur_pid | input | 8 | Current process ID, for tag capture and matching |
| lk_req | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address |
| lk_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| lk_user | input | 1 | 1 for user mode, 0 for supervisor |
| zpr | input | 32 | Zone protection word, 2 bits per zone |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_status | output | 2 | 0 ok, 1 instruction miss, 2 data miss, 3 protection fault |
| rsp_pa | output | 32 | Physical address |
| rsp_rd | output | 1 | Read right granted |
| rsp_wr | output | 1 | Write right granted |
| rsp_attr | output | 8 | Attributes of the matching entry |
| fault_addr | output | 32 | Address of the last miss |
| syndrome | output | 32 | Syndrome of the last miss |

## Verification
Corrupted entry state shows at the ports on the first lookup that touches the page. A wrong size code or page alignment moves the hit window, so a hit turns into a miss, or a miss into a hit, at the page edges that the size sweep probes. A wrong permission field or zone selection changes the status or rights in the cycle after the request; the rights sweep pairs every zone code with a different code in the other zones so that a misplaced field shows. A fault register that updates at the wrong time is caught at once by comparing it with the last miss.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;

   localparam int VA_W      = 32;
   localparam int OFF_MIN   = 10;
   localparam int PN_W      = VA_W - OFF_MIN;
   localparam int SZ_W      = 3;
   localparam int ATTR_W    = 8;
   localparam int ZIDX_W    = 4;

   // field positions inside the two write words
   localparam int TAG_VALID_BIT = 6;
   localparam int TAG_SZ_LSB    = 7;
   localparam int PERM_WR_BIT   = 8;
   localparam int PERM_EX_BIT   = 9;
   localparam int PERM_ZONE_LSB = 4;

   localparam logic [VA_W-1:0] SYN_STORE = 32'h0080_0000;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      RSP_OK    = 2'd0,
      RSP_IMISS = 2'd1,
      RSP_DMISS = 2'd2,
      RSP_PROT  = 2'd3
   } rsp_e;

   typedef struct packed {
      logic              valid;
      logic [PN_W-1:0]   vpn;
      logic [SZ_W-1:0]   size;
      logic [ATTR_W-1:0] attr;
   } tag_t;

   typedef struct packed {
      logic [PN_W-1:0]   ppn;
      logic              ex;
      logic              wr;
      logic [ZIDX_W-1:0] zone;
   } perm_t;

   // page-number bits that take part in the compare for size code sz
   function automatic logic [PN_W-1:0] pn_mask(input logic [SZ_W-1:0] sz);
      logic [PN_W-1:0] low;
      low = (PN_W'(1) << (2 * int'(sz))) - PN_W'(1);
      return ~low;
   endfunction

endpackage

// File: rtl/swtlb_bank.sv
module swtlb_bank
   import swtlb_pkg::*;
#(
   parameter int ENTRIES = 64,
   parameter int PID_W   = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_tag_en,
   input  logic               wr_perm_en,
   input  logic [IDX_W-1:0]   wr_sel,
   input  logic [VA_W-1:0]    wr_word,
   input  logic [PID_W-1:0]   cur_pid,
   input  logic [PN_W-1:0]    lk_pn,
   input  logic [IDX_W-1:0]   rd_sel,
   output logic [ENTRIES-1:0] hit_vec,
   output tag_t               sel_tag,
   output perm_t              sel_perm
);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("swtlb_bank: ENTRIES must be at least 2");
   end
   if (ENTRIES != (1 << IDX_W)) begin : g_bad_pow2
      $error("swtlb_bank: ENTRIES must be a power of two");
   end
   if (PID_W < 1) begin : g_bad_pid
      $error("swtlb_bank: PID_W must be positive");
   end

   tag_t  tags  [ENTRIES];
   perm_t perms [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      tag_t             tag_q;
      perm_t            perm_q;
      logic [PID_W-1:0] pid_q;
      logic             sel_me;
      logic [SZ_W-1:0]  new_sz;
      logic             pid_ok;
      logic             pn_ok;

      assign sel_me = (wr_sel == IDX_W'(g));
      assign new_sz = wr_word[TAG_SZ_LSB +: SZ_W];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_q  <= '0;
            perm_q <= '0;
            pid_q  <= '0;
         end else begin
            if (wr_tag_en && sel_me) begin
               tag_q.valid <= wr_word[TAG_VALID_BIT];
               tag_q.size  <= new_sz;
               tag_q.vpn   <= wr_word[VA_W-1:OFF_MIN] & pn_mask(new_sz);
               tag_q.attr  <= wr_word[ATTR_W-1:0];
               pid_q       <= cur_pid;
            end
            if (wr_perm_en && sel_me) begin
               perm_q.ppn  <= wr_word[VA_W-1:OFF_MIN];
               perm_q.wr   <= wr_word[PERM_WR_BIT];
               perm_q.ex   <= wr_word[PERM_EX_BIT];
               perm_q.zone <= wr_word[PERM_ZONE_LSB +: ZIDX_W];
            end
         end
      end

      assign pid_ok     = (pid_q == cur_pid) || (pid_q == '0);
      assign pn_ok      = ((lk_pn ^ tag_q.vpn) & pn_mask(tag_q.size)) == '0;
      assign hit_vec[g] = tag_q.valid && pid_ok && pn_ok;
      assign tags[g]    = tag_q;
      assign perms[g]   = perm_q;

      // R2
      tag_valid_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_tag_en && sel_me) |=> (tag_q.valid == $past(wr_word[TAG_VALID_BIT])));

      // R2
      tag_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((tag_q.vpn & ~pn_mask(tag_q.size)) == '0));
   end

   assign sel_tag  = tags[rd_sel];
   assign sel_perm = perms[rd_sel];

endmodule

// File: rtl/swtlb_prio.sv
module swtlb_prio #(
   parameter int N      = 64,
   parameter int IMPL   = 1,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   if (N < 2) begin : g_bad_n
      $error("swtlb_prio: N must be at least 2");
   end
   if (IMPL != 0 && IMPL != 1) begin : g_bad_impl
      $error("swtlb_prio: IMPL must be 0 (chain) or 1 (prefix)");
   end

   if (IMPL == 0) begin : g_chain
      always_comb begin
         logic taken;
         taken = 1'b0;
         grant = '0;
         for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
               grant[i] = 1'b1;
               taken    = 1'b1;
            end
         end
      end
   end else begin : g_prefix
      always_comb begin
         logic [N-1:0] below;
         below = req;
         for (int s = 1; s < N; s = s * 2) begin
            below = below | (below << s);
         end
         grant = req & ~(below << 1);
      end
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = idx | IDX_W'(i);
      end
      any = |grant;
   end

   // R5
   always_comb begin
      grant_onehot_chk: assert ($onehot0(grant));
      // R5
      grant_any_chk: assert ((|req) == any);
   end

endmodule

// File: rtl/swtlb_rights.sv
module swtlb_rights
   import swtlb_pkg::*;
(
   input  logic [1:0] zcode,
   input  logic       user,
   input  logic       is_fetch,
   input  logic       is_store,
   input  logic       ent_ex,
   input  logic       ent_wr,
   output logic       rd_ok,
   output logic       wr_ok,
   output logic       fault
);

   always_comb begin
      rd_ok = 1'b0;
      wr_ok = 1'b0;
      fault = 1'b0;
      if (zcode == 2'd0 && user) begin
         fault = 1'b1;
      end else if (zcode == 2'd3) begin
         rd_ok = 1'b1;
         wr_ok = 1'b1;
      end else if (is_fetch) begin
         if (ent_ex) begin
            rd_ok = 1'b1;
            wr_ok = ent_wr;
         end else begin
            fault = 1'b1;
         end
      end else if (ent_wr) begin
         rd_ok = 1'b1;
         wr_ok = 1'b1;
      end else if (is_store) begin
         fault = 1'b1;
      end else begin
         rd_ok = 1'b1;
      end
   end

   // R9
   always_comb begin
      rights_fault_chk: assert (!(fault && (rd_ok || wr_ok)));
      // R10
      rights_order_chk: assert (!(wr_ok && !rd_ok));
   end

endmodule

// File: rtl/swtlb_zone.sv
module swtlb_zone
   import swtlb_pkg::*;
#(
   parameter int ENTRIES   = 64,
   parameter int PID_W     = 8,
   parameter int ZONES     = 16,
   parameter int PRIO_IMPL = 1,
   localparam int IDX_W    = $clog2(ENTRIES),
   localparam int ZPR_W    = 2 * ZONES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_tag,
   input  logic              wr_perm,
   input  logic [31:0]       wr_index,
   input  logic [31:0]       wr_data,
   input  logic [PID_W-1:0]  cur_pid,
   input  logic              lk_req,
   input  logic [31:0]       lk_ea,
   input  logic [1:0]        lk_acc,
   input  logic              lk_user,
   input  logic [ZPR_W-1:0]  zpr,
   output logic              rsp_valid,
   output logic [1:0]        rsp_status,
   output logic [31:0]       rsp_pa,
   output logic              rsp_rd,
   output logic              rsp_wr,
   output logic [7:0]        rsp_attr,
   output logic [31:0]       fault_addr,
   output logic [31:0]       syndrome
);

   if (ZONES != (1 << ZIDX_W)) begin : g_bad_zones
      $error("swtlb_zone: ZONES must match the 4-bit zone index field");
   end
   if (IDX_W > 32) begin : g_bad_idx
      $error("swtlb_zone: index operand is 32 bits wide");
   end

   logic [PN_W-1:0]    lk_pn;
   logic [ENTRIES-1:0] hit_vec;
   logic [ENTRIES-1:0] grant;
   logic [IDX_W-1:0]   win_idx;
   logic               any_hit;
   tag_t               win_tag;
   perm_t              win_perm;
   logic [1:0]         zcode;
   logic               is_fetch;
   logic               is_store;
   logic               rd_ok;
   logic               wr_ok;
   logic               prot_fault;
   logic [PN_W-1:0]    win_mask;
   logic [VA_W-1:0]    pa_n;

   assign lk_pn    = lk_ea[VA_W-1:OFF_MIN];
   assign is_fetch = (lk_acc == ACC_FETCH);
   assign is_store = (lk_acc == ACC_STORE);

   swtlb_bank #(
      .ENTRIES (ENTRIES),
      .PID_W   (PID_W)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_tag_en  (wr_tag),
      .wr_perm_en (wr_perm),
      .wr_sel     (wr_index[IDX_W-1:0]),
      .wr_word    (wr_data),
      .cur_pid    (cur_pid),
      .lk_pn      (lk_pn),
      .rd_sel     (win_idx),
      .hit_vec    (hit_vec),
      .sel_tag    (win_tag),
      .sel_perm   (win_perm)
   );

   swtlb_prio #(
      .N    (ENTRIES),
      .IMPL (PRIO_IMPL)
   ) u_prio (
      .req   (hit_vec),
      .grant (grant),
      .idx   (win_idx),
      .any   (any_hit)
   );

   // zone z lives at bits (ZPR_W-1-2z):(ZPR_W-2-2z)
   always_comb begin
      logic [ZPR_W-1:0] shifted;
      shifted = zpr >> (ZPR_W - 2 - 2 * int'(win_perm.zone));
      zcode   = shifted[1:0];
   end

   swtlb_rights u_rights (
      .zcode    (zcode),
      .user     (lk_user),
      .is_fetch (is_fetch),
      .is_store (is_store),
      .ent_ex   (win_perm.ex),
      .ent_wr   (win_perm.wr),
      .rd_ok    (rd_ok),
      .wr_ok    (wr_ok),
      .fault    (prot_fault)
   );

   assign win_mask = pn_mask(win_tag.size);
   assign pa_n     = {(win_perm.ppn & win_mask) | (lk_pn & ~win_mask),
                      lk_ea[OFF_MIN-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_status <= RSP_OK;
         rsp_pa     <= '0;
         rsp_rd     <= 1'b0;
         rsp_wr     <= 1'b0;
         rsp_attr   <= '0;
         fault_addr <= '0;
         syndrome   <= '0;
      end else begin
         rsp_valid <= lk_req;
         if (lk_req) begin
            if (!any_hit) begin
               rsp_status <= is_fetch ? RSP_IMISS : RSP_DMISS;
               rsp_pa     <= '0;
               rsp_rd     <= 1'b0;
               rsp_wr     <= 1'b0;
               rsp_attr   <= '0;
               fault_addr <= lk_ea;
               syndrome   <= is_store ? SYN_STORE : '0;
            end else if (prot_fault) begin
               rsp_status <= RSP_PROT;
               rsp_pa     <= '0;
               rsp_rd     <= 1'b0;
               rsp_wr     <= 1'b0;
               rsp_attr   <= '0;
            end else begin
               rsp_status <= RSP_OK;
               rsp_pa     <= pa_n;
               rsp_rd     <= rd_ok;
               rsp_wr     <= wr_ok;
               rsp_attr   <= win_tag.attr;
            end
         end
      end
   end

   // R12
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> rsp_valid);

   // R12
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> !rsp_valid);

   // R8
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_valid && (rsp_status == RSP_IMISS || rsp_status == RSP_DMISS))
      |-> ($stable(fault_addr) && $stable(syndrome)));

   // R8
   imiss_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == RSP_IMISS) |-> (syndrome == '0));

   // R10
   ok_has_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == RSP_OK) |-> rsp_rd);

   // R5
   hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_hit |-> win_tag.valid);

   // R7
   miss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status != RSP_OK) |-> (!rsp_rd && !rsp_wr && rsp_pa == '0));

endmodule

// File: tb/sim_swtlb_zone.sv
`timescale 1ns/1ps
module sim_swtlb_zone;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_tag = 1'b0;
   logic        wr_perm = 1'b0;
   logic [31:0] wr_index = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  cur_pid = '0;
   logic        lk_req = 1'b0;
   logic [31:0] lk_ea = '0;
   logic [1:0]  lk_acc = '0;
   logic        lk_user = 1'b0;
   logic [31:0] zpr = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_status;
   logic [31:0] rsp_pa;
   logic        rsp_rd;
   logic        rsp_wr;
   logic [7:0]  rsp_attr;
   logic [31:0] fault_addr;
   logic [31:0] syndrome;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   swtlb_zone u0 (
      .clk(clk), .rst_n(rst_n), .wr_tag(wr_tag), .wr_perm(wr_perm),
      .wr_index(wr_index), .wr_data(wr_data), .cur_pid(cur_pid),
      .lk_req(lk_req), .lk_ea(lk_ea), .lk_acc(lk_acc), .lk_user(lk_user),
      .zpr(zpr), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
      .rsp_pa(rsp_pa), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
      .rsp_attr(rsp_attr), .fault_addr(fault_addr), .syndrome(syndrome)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input bit tag_side, input logic [31:0] idx, input logic [31:0] data);
      @(negedge clk);
      wr_tag   = tag_side;
      wr_perm  = !tag_side;
      wr_index = idx;
      wr_data  = data;
      @(negedge clk);
      wr_tag  = 1'b0;
      wr_perm = 1'b0;
   endtask

   task automatic look(input logic [31:0] ea, input logic [1:0] acc,
                       input bit user, input logic [31:0] z);
      @(negedge clk);
      lk_req  = 1'b1;
      lk_ea   = ea;
      lk_acc  = acc;
      lk_user = user;
      zpr     = z;
      @(negedge clk);
      lk_req = 1'b0;
   endtask

   // expected {status, rd, wr} from the zone rules
   function automatic logic [3:0] exp_rights(input int code, input bit user,
                                             input int acc, input bit ex, input bit w);
      if (code == 0 && user) return {2'd3, 2'b00};
      if (code == 3)         return {2'd0, 2'b11};
      if (acc == 0) return ex ? {2'd0, 1'b1, w} : {2'd3, 2'b00};
      if (w)        return {2'd0, 2'b11};
      if (acc == 2) return {2'd3, 2'b00};
      return {2'd0, 2'b10};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8 reset state
      chk("R8 reset fault_addr", fault_addr, 0);
      chk("R8 reset syndrome", syndrome, 0);
      chk("R12 reset rsp_valid", rsp_valid, 0);
      rst_n = 1'b1;

      // R7 empty table miss on fetch
      look(32'h1234_5678, 2'd0, 1'b0, 32'hFFFF_FFFF);
      chk("R7 empty fetch miss", {rsp_valid, rsp_status}, {1'b1, 2'd1});

      // R2 R3 R4 R6 size sweep on entry 5
      cur_pid = 8'd3;
      for (int n = 0; n < 8; n++) begin
         logic [31:0] ps, base, hi, lo, ea;
         ps   = 32'd1024 << (2 * n);
         hi   = 32'hA5A5_A400 | (n << 7) | 32'h40 | 32'h15;
         base = 32'hA5A5_A400 & ~(ps - 1);
         lo   = 32'h5A5A_5C00 | (1 << 9) | (1 << 8) | (2 << 4);
         wr(1'b1, 32'd5, hi);
         wr(1'b0, 32'd5, lo);
         ea = base + ps - 4;
         look(ea, 2'd1, 1'b1, 32'hFFFF_FFFF);
         chk($sformatf("R6 size%0d pa", n), {rsp_status, rsp_pa},
             {2'd0, (lo & ~(ps - 1) & 32'hFFFF_FC00) | (ea & (ps - 1))});
         chk($sformatf("R3 size%0d attr", n), rsp_attr, hi[7:0]);
         look(base + ps, 2'd1, 1'b1, 32'hFFFF_FFFF);
         chk($sformatf("R2 size%0d above", n), rsp_status, 2'd2);
         look(base - 4, 2'd2, 1'b1, 32'hFFFF_FFFF);
         chk($sformatf("R2 size%0d below", n), rsp_status, 2'd2);
      end

      // R2 valid bit cleared
      wr(1'b1, 32'd5, 32'hA5A5_A400);
      look(32'hA5A5_A404, 2'd1, 1'b0, 32'hFFFF_FFFF);
      chk("R2 invalid entry misses", rsp_status, 2'd2);

      // R1 index operand upper bits ignored
      wr(1'b1, 32'd73, 32'hB000_0040);
      wr(1'b0, 32'd73, 32'hC000_0000);
      look(32'hB000_0010, 2'd1, 1'b0, 32'hFFFF_FFFF);
      chk("R1 alias write hits", {rsp_status, rsp_pa}, {2'd0, 32'hC000_0010});
      wr(1'b1, 32'd9, 32'hB000_0000);
      look(32'hB000_0010, 2'd1, 1'b0, 32'hFFFF_FFFF);
      chk("R1 same entry cleared", rsp_status, 2'd2);

      // R5 process tag match
      cur_pid = 8'd7;
      wr(1'b1, 32'd10, 32'hD000_0040);
      wr(1'b0, 32'd10, 32'hD100_0000);
      look(32'hD000_0004, 2'd1, 1'b0, 32'hFFFF_FFFF);
      chk("R5 pid equal hits", rsp_status, 2'd0);
      cur_pid = 8'd8;
      look(32'hD000_0004, 2'd1, 1'b0, 32'hFFFF_FFFF);
      chk("R5 pid differs misses", rsp_status, 2'd2);
      cur_pid = 8'd0;
      wr(1'b1, 32'd11, 32'hE000_0040);
      wr(1'b0, 32'd11, 32'hE100_0000);
      cur_pid = 8'd200;
      look(32'hE000_0008, 2'd1, 1'b0, 32'hFFFF_FFFF);
      chk("R5 pid zero global", {rsp_status, rsp_pa}, {2'd0, 32'hE100_0008});

      // R5 lowest index wins
      wr(1'b1, 32'd21, 32'h3000_0040);
      wr(1'b0, 32'd21, 32'h2222_2000);
      wr(1'b1, 32'd20, 32'h3000_0040);
      wr(1'b0, 32'd20, 32'h1111_1000);
      look(32'h3000_0020, 2'd1, 1'b0, 32'hFFFF_FFFF);
      chk("R5 priority low index", rsp_pa, 32'h1111_1020);
      wr(1'b1, 32'd20, 32'h3000_0000);
      look(32'h3000_0020, 2'd1, 1'b0, 32'hFFFF_FFFF);
      chk("R5 next entry after invalidate", rsp_pa, 32'h2222_2020);

      // R9 R10 R11 rights sweep on entry 30
      wr(1'b1, 32'd30, 32'h4000_0040);
      for (int ex = 0; ex < 2; ex++)
         for (int w = 0; w < 2; w++)
            for (int code = 0; code < 4; code++)
               for (int user = 0; user < 2; user++)
                  for (int acc = 0; acc < 3; acc++) begin
                     int          z;
                     logic [31:0] zw;
                     logic [3:0]  e;
                     z = (ex * 5 + w * 3 + code * 7 + user * 11 + acc) % 16;
                     wr(1'b0, 32'd30, 32'h7000_0000 | (ex << 9) | (w << 8) | (z << 4));
                     zw = '0;
                     for (int k = 0; k < 16; k++)
                        zw[31 - 2*k -: 2] = (k == z) ? 2'(code) : 2'(~code);
                     look(32'h4000_0123, 2'(acc), 1'(user), zw);
                     e = exp_rights(code, 1'(user), acc, 1'(ex), 1'(w));
                     chk($sformatf("%s R11 ex%0d w%0d code%0d u%0d acc%0d",
                                   (acc == 0) ? "R9" : "R10", ex, w, code, user, acc),
                         {rsp_status, rsp_rd, rsp_wr, rsp_pa},
                         {e, (e[3:2] == 2'd0) ? 32'h7000_0123 : 32'h0});
                  end

      // R8 miss syndrome and fault address
      look(32'h9000_0010, 2'd2, 1'b0, 32'hFFFF_FFFF);
      chk("R8 store miss", {rsp_status, fault_addr, syndrome},
          {2'd2, 32'h9000_0010, 32'h0080_0000});
      look(32'h9000_0020, 2'd1, 1'b0, 32'hFFFF_FFFF);
      chk("R8 load miss", {rsp_status, fault_addr, syndrome},
          {2'd2, 32'h9000_0020, 32'h0});
      look(32'h9000_0030, 2'd0, 1'b1, 32'hFFFF_FFFF);
      chk("R7 R8 fetch miss", {rsp_status, fault_addr, syndrome},
          {2'd1, 32'h9000_0030, 32'h0});
      wr(1'b0, 32'd30, 32'h7000_0000);
      look(32'h4000_0000, 2'd2, 1'b1, 32'h0);
      chk("R8 prot fault keeps regs", {rsp_status, fault_addr, syndrome},
          {2'd3, 32'h9000_0030, 32'h0});
      look(32'h3000_0000, 2'd1, 1'b0, 32'hFFFF_FFFF);
      chk("R8 hit keeps regs", {rsp_status, fault_addr}, {2'd0, 32'h9000_0030});

      // R12 same-cycle write is not seen, next cycle is
      @(negedge clk);
      wr_tag   = 1'b1;
      wr_index = 32'd40;
      wr_data  = 32'h6000_0040;
      lk_req   = 1'b1;
      lk_ea    = 32'h6000_0100;
      lk_acc   = 2'd1;
      lk_user  = 1'b0;
      zpr      = 32'hFFFF_FFFF;
      @(negedge clk);
      wr_tag = 1'b0;
      chk("R12 same cycle sees old", {rsp_valid, rsp_status}, {1'b1, 2'd2});
      @(negedge clk);
      lk_req = 1'b0;
      chk("R12 next cycle sees new", {rsp_valid, rsp_status}, {1'b1, 2'd0});
      @(negedge clk);
      chk("R12 valid drops", rsp_valid, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule